// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a clocked host port and an external asynchronous static RAM of 1M bytes. The RAM has a 20-bit address and an 8-bit data bus. The host offers one read or one write at a time through a valid/ready handshake. The controller turns each request into one strobe sequence on the memory pins. It uses an active-low select, an active-high select, an active-low output enable, an active-low write enable and a three-state data bus. Each strobe lasts a whole number of clock cycles, and that number is set by parameters.

The timing limits are given in clock cycles, rounded up from nanoseconds. The parameters are read cycle, address access, write pulse, address-to-write-end and data setup. Two localparams are derived from them. The read window is the larger of the read-cycle and access counts, and the memory data is sampled on the last cycle of that window. The write-enable pulse is the largest of the write-pulse count, the address-to-end count, the data-setup count plus one and the read-cycle count minus one. The data bus is driven only behind a falling write enable, and output enable stays high for every write.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held and after it, the active-low select is 1 and the active-high select is 0. Output enable and write enable are both 1, req_ready is 1 and rd_valid is 0.
- R2: The block accepts a request on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge for RD_LEN+1 cycles after a read and WP_LEN+1 cycles after a write, and then returns to 1.
- R3: A read drives both selects active (active-low select 0, active-high select 1), output enable 0 and write enable 1. These levels start at the accepting edge and last exactly RD_LEN = max(TRC_CYC, TAA_CYC) cycles.
- R4: The bus is sampled at the edge that ends the read window. In the following cycle rd_valid is 1 for exactly one cycle and rd_data holds the sampled byte.
- R5: A write holds write enable at 0 for exactly WP_LEN = max(TWP_CYC, TAW_CYC, TSU_CYC+1, TRC_CYC-1) cycles with both selects active. Output enable stays 1 for the whole write.
- R6: The controller drives the write byte onto the bus from the cycle after write enable falls through the cycle after write enable rises. The byte is therefore stable for WP_LEN-1 cycles before the end of the write and is held one cycle after it.
- R7: From the accepting edge until the selects drop, mem_addr equals the accepted address and does not change.
- R8: The controller drives the bus only while output enable is 1. After a read, the cycle in which rd_valid is 1 has both selects inactive and output enable 1, and no new request is accepted in that cycle.
- R9: Between cycles the memory is deselected with both enables high. Write enable or output enable goes low only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data valid |
| rd_data | output | 8 | Byte returned by a read |
| mem_addr | output | 20 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq | inout | 8 | Three-state data bus |

## Verification
The assertions check rules that must hold on every cycle. Output enable is high whenever write enable is low. The bus driver is on only with output enable high. Strobes go low only under an active select, and the address stays fixed while the memory is selected. The write-enable pulse width, the start of the driver one cycle after write enable falls and the single-cycle rd_valid pulse are also checked each cycle. Only the bench's scenarios can show the rest. That covers the exact read-window length and the sampling point: the memory model returns a garbage byte until the access count has elapsed. It also covers the data actually stored in and returned from the memory, the handshake timing and the deselected turn-around cycle after a read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_TURN   = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int RD_LEN = 7,
    parameter int WP_LEN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              accept,
    output logic              capture,
    output logic              sel,
    output logic              oe_n,
    output logic              we_n,
    output logic              drv,
    output logic [ADDR_W-1:0] addr
);

    localparam int MAX_LEN = (RD_LEN > WP_LEN) ? RD_LEN : WP_LEN;
    localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              sel;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.sel  = 1'b1;
                    if (req_write) begin
                        r_d.state = ST_WPULSE;
                        r_d.cnt   = CNT_W'(WP_LEN - 1);
                        r_d.we_n  = 1'b0;
                    end else begin
                        r_d.state = ST_READ;
                        r_d.cnt   = CNT_W'(RD_LEN - 1);
                        r_d.oe_n  = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_TURN;
                    r_d.sel   = 1'b0;
                    r_d.oe_n  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_TURN: begin
                r_d.state = ST_IDLE;
            end
            ST_WPULSE: begin
                r_d.drv = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.state = ST_WHOLD;
                    r_d.we_n  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                r_d.state = ST_IDLE;
                r_d.drv   = 1'b0;
                r_d.sel   = 1'b0;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.sel   = 1'b0;
                r_d.oe_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.drv   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.sel   <= 1'b0;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.drv   <= 1'b0;
            r_q.addr  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (r_q.state == ST_READ) && (r_q.cnt == '0);
    assign sel       = r_q.sel;
    assign oe_n      = r_q.oe_n;
    assign we_n      = r_q.we_n;
    assign drv       = r_q.drv;
    assign addr      = r_q.addr;

    // Checker state: number of consecutive cycles with write enable low.
    logic [CNT_W:0] we_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        we_run_q <= '0;
        else if (!r_q.we_n) we_run_q <= we_run_q + 1'b1;
        else               we_run_q <= '0;
    end

    p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    p_we_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run_q == (CNT_W+1)'(WP_LEN)));
    p_drive_after_we_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> drv);
    p_no_drive_on_we_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> !drv);
    p_drive_only_oe_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> oe_n);
    p_strobe_needs_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> sel);
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> !req_ready);
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(addr));

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } dp_regs_t;

    dp_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.rd_valid = capture;
        if (accept)  r_d.wdata   = req_wdata;
        if (capture) r_d.rd_data = bus_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.wdata    <= '0;
            r_q.rd_valid <= 1'b0;
            r_q.rd_data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wdata    = r_q.wdata;
    assign rd_valid = r_q.rd_valid;
    assign rd_data  = r_q.rd_data;

    p_rd_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 8,
    parameter int TRC_CYC = 7,
    parameter int TAA_CYC = 7,
    parameter int TWP_CYC = 5,
    parameter int TAW_CYC = 6,
    parameter int TSU_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_LEN = (TRC_CYC > TAA_CYC) ? TRC_CYC : TAA_CYC;
    localparam int WP_A   = (TWP_CYC > TAW_CYC) ? TWP_CYC : TAW_CYC;
    localparam int WP_B   = (WP_A > TSU_CYC + 1) ? WP_A : TSU_CYC + 1;
    localparam int WP_LEN = (WP_B > TRC_CYC - 1) ? WP_B : TRC_CYC - 1;

    logic              accept;
    logic              capture;
    logic              sel;
    logic              drv;
    logic [DATA_W-1:0] wdata;

    sram_ctl_seq #(
        .ADDR_W (ADDR_W),
        .RD_LEN (RD_LEN),
        .WP_LEN (WP_LEN)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .sel       (sel),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .drv       (drv),
        .addr      (mem_addr)
    );

    sram_ctl_datapath #(
        .DATA_W (DATA_W)
    ) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_wdata (req_wdata),
        .capture   (capture),
        .bus_in    (mem_dq),
        .wdata     (wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign mem_sel_n = ~sel;
    assign mem_sel   = sel;
    assign mem_dq    = drv ? wdata : {DATA_W{1'bz}};

    p_selects_opposite_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel_n != mem_sel);

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb_top;

    localparam int ADDR_W  = 20;
    localparam int DATA_W  = 8;
    localparam int TRC_CYC = 7;
    localparam int TAA_CYC = 7;
    localparam int TWP_CYC = 5;
    localparam int TAW_CYC = 6;
    localparam int TSU_CYC = 4;
    localparam int RD_LEN  = (TRC_CYC > TAA_CYC) ? TRC_CYC : TAA_CYC;
    localparam int WP_A    = (TWP_CYC > TAW_CYC) ? TWP_CYC : TAW_CYC;
    localparam int WP_B    = (WP_A > TSU_CYC + 1) ? WP_A : TSU_CYC + 1;
    localparam int WP_LEN  = (WP_B > TRC_CYC - 1) ? WP_B : TRC_CYC - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_sel_n, mem_sel, mem_oe_n, mem_we_n;
    wire  [DATA_W-1:0] mem_dq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sram_async_ctl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .TRC_CYC (TRC_CYC), .TAA_CYC (TAA_CYC),
        .TWP_CYC (TWP_CYC), .TAW_CYC (TAW_CYC), .TSU_CYC (TSU_CYC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data), .mem_addr (mem_addr),
        .mem_sel_n (mem_sel_n), .mem_sel (mem_sel), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n), .mem_dq (mem_dq)
    );

    // Behavioural memory: sparse store, garbage until the access count elapses.
    logic [DATA_W-1:0] store [logic [ADDR_W-1:0]];
    logic [DATA_W-1:0] model_out = 8'hEE;
    int                rd_cnt = 0;
    logic              model_drv;

    function automatic logic [DATA_W-1:0] dflt(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ a[19:12] ^ 8'h3C;
    endfunction

    function automatic logic [DATA_W-1:0] peek(input logic [ADDR_W-1:0] a);
        if (store.exists(a)) return store[a];
        return dflt(a);
    endfunction

    assign model_drv = (mem_sel_n === 1'b0) && (mem_sel === 1'b1) &&
                       (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
    assign mem_dq = model_drv ? model_out : {DATA_W{1'bz}};

    always @(negedge clk) begin
        if (model_drv) begin
            rd_cnt    <= rd_cnt + 1;
            model_out <= (rd_cnt + 1 >= TAA_CYC) ? peek(mem_addr) : 8'hEE;
        end else begin
            rd_cnt    <= 0;
            model_out <= 8'hEE;
        end
    end

    always @(posedge mem_we_n) begin
        if (mem_sel_n === 1'b0 && mem_sel === 1'b1) store[mem_addr] = mem_dq;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R1", "sel_n in reset", int'(mem_sel_n), 1);
        check_eq("R1", "sel in reset", int'(mem_sel), 0);
        check_eq("R1", "oe_n/we_n in reset", int'({mem_oe_n, mem_we_n}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ready/rd_valid after reset", int'({req_ready, rd_valid}), 2);
        check_eq("R9", "deselected idle", int'({mem_sel_n, mem_sel, mem_oe_n, mem_we_n}), 4'b1011);
    endtask

    task automatic t_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int we_low = 0, oe_low = 0, bad_drv = 0, bad_addr = 0, bad_sel = 0, bad_rdy = 0;
        issue(1'b1, a, d);
        for (int i = 1; i <= WP_LEN + 1; i++) begin
            if (mem_we_n == 1'b0) we_low++;
            if (mem_oe_n == 1'b0) oe_low++;
            if (i >= 2 && mem_dq !== d) bad_drv++;
            if (mem_addr != a) bad_addr++;
            if (!(mem_sel_n == 1'b0 && mem_sel == 1'b1)) bad_sel++;
            if (req_ready) bad_rdy++;
            @(negedge clk);
        end
        check_eq("R5", "write enable low cycles", we_low, WP_LEN);
        check_eq("R5", "oe low cycles during write", oe_low, 0);
        check_eq("R6", "bus drive mismatches", bad_drv, 0);
        check_eq("R7", "address changes in write", bad_addr, 0);
        check_eq("R9", "select inactive during write", bad_sel, 0);
        check_eq("R2", "ready during write", bad_rdy, 0);
        check_eq("R2", "ready after write", int'(req_ready), 1);
        check_eq("R9", "deselected after write", int'({mem_sel_n, mem_sel}), 2);
        check_eq("R6", "byte stored", int'(peek(a)), int'(d));
    endtask

    task automatic t_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        int oe_low = 0, bad_we = 0, bad_addr = 0, bad_sel = 0, bad_rdy = 0, early_v = 0;
        issue(1'b0, a, 8'h00);
        for (int i = 1; i <= RD_LEN; i++) begin
            if (mem_oe_n == 1'b0) oe_low++;
            if (mem_we_n == 1'b0) bad_we++;
            if (mem_addr != a) bad_addr++;
            if (!(mem_sel_n == 1'b0 && mem_sel == 1'b1)) bad_sel++;
            if (req_ready) bad_rdy++;
            if (rd_valid) early_v++;
            @(negedge clk);
        end
        check_eq("R3", "oe low cycles", oe_low, RD_LEN);
        check_eq("R3", "we low during read", bad_we, 0);
        check_eq("R3", "select inactive during read", bad_sel, 0);
        check_eq("R7", "address changes in read", bad_addr, 0);
        check_eq("R4", "rd_valid before window end", early_v, 0);
        check_eq("R4", "rd_valid pulse", int'(rd_valid), 1);
        check_eq("R4", "read data", int'(rd_data), int'(exp));
        check_eq("R8", "turn cycle strobes", int'({mem_sel_n, mem_sel, mem_oe_n}), 3'b101);
        check_eq("R8", "ready in turn cycle", int'(req_ready) + bad_rdy, 0);
        @(negedge clk);
        check_eq("R4", "rd_valid single cycle", int'(rd_valid), 0);
        check_eq("R2", "ready after read", int'(req_ready), 1);
    endtask

    task automatic t_boundaries();
        t_write(20'h00000, 8'hA5);
        t_write(20'hFFFFF, 8'h5A);
        t_read(20'h00000, 8'hA5);
        t_read(20'hFFFFF, 8'h5A);
        t_read(20'h12345, dflt(20'h12345));
    endtask

    task automatic t_overwrite();
        t_write(20'h00777, 8'h11);
        t_write(20'h00777, 8'hFE);
        t_read(20'h00777, 8'hFE);
    endtask

    task automatic t_back_to_back();
        t_read(20'h00777, 8'hFE);
        t_write(20'h00778, 8'h00);
        t_read(20'h00778, 8'h00);
        t_write(20'h00777, 8'hFF);
        t_read(20'h00777, 8'hFF);
    endtask

    task automatic t_random();
        logic [ADDR_W-1:0] addrs [8];
        logic [DATA_W-1:0] vals [8];
        for (int k = 0; k < 8; k++) begin
            addrs[k] = ADDR_W'($urandom) ^ ADDR_W'(k << 16);
            vals[k]  = DATA_W'($urandom);
            t_write(addrs[k], vals[k]);
        end
        for (int k = 7; k >= 0; k--) t_read(addrs[k], peek(addrs[k]));
        for (int k = 0; k < 8; k++) check_eq("R4", "random readback", int'(peek(addrs[k])), int'(vals[k]));
    endtask

    logic done = 1'b0;

    initial begin
        void'($urandom(32'h1234));
        t_reset();
        t_boundaries();
        t_overwrite();
        t_back_to_back();
        t_random();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule